// File: doc/BRIEF.md
# Zero-Overhead Loop Repeat Controller

This block sits next to an instruction fetch unit and repeats code in hardware without branch instructions. Software first loads three values through a small write port: the address of the first instruction of the loop body, the address of its last instruction, and a repeat count. A start command then arms the controller in one of two forms.

In block form, the controller watches every fetch. When the fetch address equals the loaded end address and the count is nonzero, it tells the fetch unit to take the loaded start address as the next program counter, and it lowers the count by one. When the end address is fetched with a count of zero, the loop is finished: no redirect is raised, the controller disarms and fetch continues in sequence. A loaded count of N therefore runs the body N+1 times, and the instruction after the body runs once.

In single form, the controller raises a fetch-hold so that the fetch unit keeps the program counter and reissues the same instruction. Each held fetch lowers the count. The fetch made with a count of zero is not held and ends the loop, so that one instruction issues N+1 times. Loop values cannot be changed while a loop is armed.

Top module: `loop_repeat_ctrl`

## Requirements
- R1: After reset `active`, `redirect` and `fetch_hold` are 0 and `count` reads 0.
- R2: While idle, a write with `wr_en`=1 stores `wr_data` according to `wr_sel`: 0 loads the loop start address, 1 the loop end address, 2 the repeat count (seen on `count` from the next cycle); `wr_sel`=3 changes nothing.
- R3: While idle, `start`=1 arms the controller: `active` is 1 from the next cycle, in block form when `start_mode`=0 and single form when `start_mode`=1.
- R4: In block form, a cycle with `fetch_valid`=1, `fetch_addr` equal to the end address and a nonzero count raises `redirect` in that same cycle with `redirect_addr` equal to the start address; `count` is one lower from the next cycle.
- R5: In block form, a valid fetch of the end address with a count of zero raises no redirect, and `active` is 0 from the next cycle; a loaded count of N makes the body run N+1 times and the following instruction once.
- R6: Cycles with `fetch_valid`=0, or block-form fetches at any address other than the end address, change neither `count` nor `active` and raise no output.
- R7: In single form, each valid fetch with a nonzero count raises `fetch_hold` in that cycle and lowers `count` by one; the valid fetch with a count of zero raises no hold and `active` is 0 from the next cycle, so the instruction issues N+1 times.
- R8: While `active` is 1, writes and `start` are ignored: addresses, count and form stay as they were.
- R9: `redirect` and `fetch_hold` are never 1 together, and both are 0 whenever `active` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loop register write strobe |
| wr_sel | input | 2 | Write target: 0 start, 1 end, 2 count, 3 none |
| wr_data | input | AW | Write data |
| start | input | 1 | Arm a loop |
| start_mode | input | 1 | 0 block form, 1 single form |
| fetch_valid | input | 1 | A fetch happens this cycle |
| fetch_addr | input | AW | Address of this cycle's fetch |
| redirect | output | 1 | Next fetch must come from `redirect_addr` |
| redirect_addr | output | AW | Loop start address |
| fetch_hold | output | 1 | Keep the program counter and reissue |
| active | output | 1 | A loop is armed |
| count | output | CW | Remaining repeat count |

## Verification
The assertions watch on every cycle that redirect and hold are exclusive and only occur while armed, that each consumed pass lowers the count by exactly one, that a count of zero at the loop end disarms the controller, and that addresses and count stay frozen while armed. Only the bench's scenarios show the totals: that a program counter driven by the outputs really executes the body N+1 times and the next instruction once, in both forms, with fetch bubbles inside the loop, and with a zero count.

// File: rtl/loop_rpt_pkg.sv
package loop_rpt_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;

  typedef enum logic {
    MODE_BLOCK  = 1'b0,
    MODE_SINGLE = 1'b1
  } rpt_mode_e;
endpackage

// File: rtl/loop_addr_regs.sv
module loop_addr_regs
  import loop_rpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  wr_sel_e       sel_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] start_addr_o,
  output logic [AW-1:0] end_addr_o
);
  logic [AW-1:0] start_q, end_q;
  logic          start_en, end_en;

  always_comb begin
    start_en = wr_en_i && (sel_i == SEL_START);
    end_en   = wr_en_i && (sel_i == SEL_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (start_en) start_q <= data_i;
      if (end_en)   end_q   <= data_i;
    end
  end

  assign start_addr_o = start_q;
  assign end_addr_o   = end_q;

  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(start_q) && $stable(end_q)));
endmodule

// File: rtl/loop_count.sv
module loop_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (dec_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - ONE));
  p_count_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_rpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  rpt_mode_e mode_i,
  input  logic      fetch_valid_i,
  input  logic      at_end_i,
  input  logic      cnt_zero_i,
  output logic      active_o,
  output logic      consume_o,
  output logic      redirect_o,
  output logic      hold_o
);
  logic      act_q, act_d, arm;
  rpt_mode_e mode_q;

  always_comb begin
    arm       = !act_q && start_i;
    consume_o = act_q && fetch_valid_i && ((mode_q == MODE_SINGLE) || at_end_i);
    redirect_o = consume_o && (mode_q == MODE_BLOCK) && !cnt_zero_i;
    hold_o     = consume_o && (mode_q == MODE_SINGLE) && !cnt_zero_i;
    act_d = act_q;
    if (arm) act_d = 1'b1;
    else if (consume_o && cnt_zero_i) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      mode_q <= MODE_BLOCK;
    end else begin
      act_q <= act_d;
      if (arm) mode_q <= mode_i;
    end
  end

  assign active_o = act_q;

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_o && hold_o));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (!redirect_o && !hold_o));
  p_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_o && cnt_zero_i) |=> !active_o);
  p_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && start_i) |=> active_o);
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !(consume_o && cnt_zero_i)) |=> (active_o && $stable(mode_q)));
endmodule

// File: rtl/loop_repeat_ctrl.sv
module loop_repeat_ctrl
  import loop_rpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          start,
  input  logic          start_mode,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          redirect,
  output logic [AW-1:0] redirect_addr,
  output logic          fetch_hold,
  output logic          active,
  output logic [CW-1:0] count
);
  wr_sel_e       sel;
  rpt_mode_e     mode_req;
  logic          wr_ok, cnt_load, at_end, cnt_zero, consume, dec;
  logic [AW-1:0] start_addr, end_addr;

  always_comb begin
    sel      = wr_sel_e'(wr_sel);
    mode_req = rpt_mode_e'(start_mode);
    wr_ok    = wr_en && !active;
    cnt_load = wr_ok && (sel == SEL_COUNT);
    at_end   = (fetch_addr == end_addr);
    dec      = consume && !cnt_zero;
  end

  loop_addr_regs #(.AW(AW)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_ok),
    .sel_i        (sel),
    .data_i       (wr_data),
    .start_addr_o (start_addr),
    .end_addr_o   (end_addr)
  );

  loop_count #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (wr_data[CW-1:0]),
    .dec_i      (dec),
    .cnt_o      (count),
    .zero_o     (cnt_zero)
  );

  loop_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .mode_i        (mode_req),
    .fetch_valid_i (fetch_valid),
    .at_end_i      (at_end),
    .cnt_zero_i    (cnt_zero),
    .active_o      (active),
    .consume_o     (consume),
    .redirect_o    (redirect),
    .hold_o        (fetch_hold)
  );

  assign redirect_addr = start_addr;

  p_wr_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_en) |=> ($stable(redirect_addr) && (count <= $past(count))));
  p_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fetch_valid) |=> ($stable(count) && active));
endmodule

// File: tb/loop_repeat_ctrl_test.sv
`timescale 1ns/1ps
module loop_repeat_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic        start_mode = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        redirect, fetch_hold, active;
  logic [31:0] redirect_addr, count;

  int total = 0;
  int bad = 0;

  // behavioural model state
  logic [31:0] m_start = '0, m_end = '0, m_cnt = '0;
  logic        m_act = 1'b0, m_single = 1'b0;
  logic        o_red, o_hold;
  logic [31:0] o_raddr;
  int          hits [0:15];

  always #2.5 clk = ~clk;

  loop_repeat_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .start_mode(start_mode), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .redirect(redirect), .redirect_addr(redirect_addr),
    .fetch_hold(fetch_hold), .active(active), .count(count)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive after negedge, compare against model, advance model
  task automatic step(input string tag, input logic we, input logic [1:0] sel,
                      input logic [31:0] d, input logic st, input logic md,
                      input logic fv, input logic [31:0] fa);
    logic e_red, e_hold, cons;
    wr_en = we; wr_sel = sel; wr_data = d; start = st; start_mode = md;
    fetch_valid = fv; fetch_addr = fa;
    #1;
    e_red  = m_act && !m_single && fv && (fa == m_end) && (m_cnt != 0);
    e_hold = m_act && m_single && fv && (m_cnt != 0);
    chk(redirect == e_red, {tag, " redirect"}, redirect, e_red);
    chk(fetch_hold == e_hold, {tag, " hold"}, fetch_hold, e_hold);
    chk(active == m_act, {tag, " active"}, active, m_act);
    chk(count == m_cnt, {tag, " count"}, count, m_cnt);
    if (e_red) chk(redirect_addr == m_start, {tag, " target"}, redirect_addr, m_start);
    o_red = redirect; o_hold = fetch_hold; o_raddr = redirect_addr;
    @(posedge clk);
    if (!m_act) begin
      if (we && sel == 2'd0) m_start = d;
      if (we && sel == 2'd1) m_end = d;
      if (we && sel == 2'd2) m_cnt = d;
      if (st) begin m_act = 1'b1; m_single = md; end
    end else begin
      cons = fv && (m_single || fa == m_end);
      if (cons) begin
        if (m_cnt != 0) m_cnt = m_cnt - 1;
        else m_act = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 2'd0, 32'd0, 0, 0, 0, 32'd0);
  endtask

  task automatic wr(input string tag, input logic [1:0] sel, input logic [31:0] d);
    step(tag, 1, sel, d, 0, 0, 0, 32'd0);
  endtask

  // run a program counter from pc0 for n cycles, steered by the outputs
  task automatic run_pc(input string tag, input logic [31:0] pc0, input int n,
                        input bit bubbles, input bit meddle);
    logic [31:0] pc;
    pc = pc0;
    for (int k = 0; k < 16; k++) hits[k] = 0;
    for (int i = 0; i < n; i++) begin
      logic fv;
      fv = !(bubbles && (i % 3 == 2));
      if (meddle && i == 5)
        step({tag, " R8 write"}, 1, 2'd1, 32'h0000_0200, 1, 1, fv, pc);
      else if (meddle && i == 6)
        step({tag, " R8 count"}, 1, 2'd2, 32'd9, 0, 0, fv, pc);
      else
        step(tag, 0, 2'd0, 32'd0, 0, 0, fv, pc);
      if (fv) begin
        if (pc >= pc0 && pc < pc0 + 16) hits[pc - pc0]++;
        if (o_red) pc = o_raddr;
        else if (!o_hold) pc = pc + 1;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(active == 0 && redirect == 0 && fetch_hold == 0 && count == 0,
        "R1 reset outputs", {active, redirect, fetch_hold}, 0);
    rst_n = 1'b1;
    idle("R1 idle");

    // R2: loading and sel 3 ignored
    wr("R2 start", 2'd0, 32'h100);
    wr("R2 end", 2'd1, 32'h103);
    wr("R2 count", 2'd2, 32'd3);
    wr("R2 sel3", 2'd3, 32'd77);
    chk(count == 3, "R2 count visible", count, 3);

    // R6: fetches while idle at end address do nothing
    step("R6 idle fetch", 0, 2'd0, 0, 0, 0, 1, 32'h103);

    // R3/R4/R5/R8: block form, count 3, with meddling writes and start
    step("R3 start block", 0, 2'd0, 0, 1, 0, 0, 0);
    chk(active == 1, "R3 armed", active, 1);
    run_pc("R4 block", 32'h100, 22, 0, 1);
    chk(hits[0] == 4, "R5 body first runs", hits[0], 4);
    chk(hits[3] == 4, "R5 body last runs", hits[3], 4);
    chk(hits[4] == 1, "R5 next runs once", hits[4], 1);
    chk(active == 0, "R5 disarmed", active, 0);

    // R6: block form with fetch bubbles
    wr("R6 count", 2'd2, 32'd2);
    step("R6 start", 0, 2'd0, 0, 1, 0, 0, 0);
    run_pc("R6 bubbles", 32'h100, 26, 1, 0);
    chk(hits[2] == 3, "R6 body runs", hits[2], 3);
    chk(hits[4] == 1, "R6 next once", hits[4], 1);

    // R5: zero count runs the body once
    wr("R5 count0", 2'd2, 32'd0);
    step("R5 start", 0, 2'd0, 0, 1, 0, 0, 0);
    run_pc("R5 zero", 32'h100, 7, 0, 0);
    chk(hits[1] == 1, "R5 zero body once", hits[1], 1);
    chk(active == 0, "R5 zero disarmed", active, 0);

    // R7: single form, count 2
    wr("R7 count", 2'd2, 32'd2);
    step("R7 start single", 0, 2'd0, 0, 1, 1, 0, 0);
    run_pc("R7 single", 32'h100, 6, 0, 0);
    chk(hits[0] == 3, "R7 issues", hits[0], 3);
    chk(hits[1] == 1, "R7 next once", hits[1], 1);
    chk(active == 0, "R7 disarmed", active, 0);

    // R7/R9: single form with bubbles
    wr("R9 count", 2'd2, 32'd4);
    step("R9 start single", 0, 2'd0, 0, 1, 1, 0, 0);
    run_pc("R9 single bubbles", 32'h100, 10, 1, 0);
    chk(hits[0] == 5, "R7 bubbles issues", hits[0], 5);
    idle("R9 idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule